// File: doc/BRIEF.md
# DMA Command Decoder with Freeze Control

This block sits between an external requester and a four-channel DMA engine. Each cycle in which `cmd_valid_i` is high, it samples a packed command made of a 2-bit channel ID, a 2-bit mode and a 3-bit size. Two encodings on channel 0 are special. The stop encoding ends channel 0 service. The flush encoding empties every pending request. Any other command is an ordinary request. It is routed by its ID either to a single pending flag for channel 0 or to a small FIFO for channels 1 to 3.

A freeze guard watches the direct-transfer mode input. If that bit changes in either direction while any channel reports busy, the block freezes. While frozen, nothing is offered to the engine and ordinary traffic is dropped. The block leaves the freeze state only when a flush command arrives while the mode bit is 1.

A stop request that is accepted clears the channel 0 enable and raises a held indication. This tells the engine to keep its channel 0 registers as they are. Service of channel 0 resumes only when software writes the enable again.

Top module: `dma_cmd_dec`

## Requirements
- R1: A command with ID 00, mode not 00 and size 111 is a stop request. If it is sampled while `ch_busy_i[0]` is 0 and the block is not frozen, `ch0_en_o` is 0 and `ch0_held_o` is 1 after that clock edge.
- R2: A stop request sampled while `ch_busy_i[0]` is 1 is ignored. `ch0_en_o` and `ch0_held_o` keep their values.
- R3: `ch0_en_set_i` high at an edge sets `ch0_en_o` to 1 and clears `ch0_held_o`. This takes priority over a stop request in the same cycle. `ch0_held_o` otherwise persists.
- R4: A command with ID 00, mode 10 and size 110 is a flush. It is honoured in every state. After the edge, all three FIFOs are empty and the channel 0 pending flag is clear.
- R5: If `ddt_mode_i` differs from its value at the previous edge while any `ch_busy_i` bit is 1, `frozen_o` is 1 after that edge. This takes priority over a flush in the same cycle.
- R6: `frozen_o` returns to 0 only after a flush sampled with `ddt_mode_i` = 1. A flush with `ddt_mode_i` = 0 leaves the block frozen.
- R7: While `frozen_o` is 1, `ch_req_o` is all zero and `ch_pop_i` has no effect. Ordinary commands and stop requests are dropped and change no FIFO, overflow flag, pending flag or enable.
- R8: An ordinary command with ID n (1 to 3) pushes {mode, size} (mode in the upper 2 bits) into FIFO n. FIFO n's oldest entry appears on `q_head_o[5*(n-1) +: 5]`, and entries leave in arrival order. The head reads 0 when the FIFO is empty.
- R9: An ordinary command with ID 00 sets the channel 0 pending flag. A set in the same cycle takes priority over a pop. `ch_req_o[0]` equals pending AND `ch0_en_o` AND NOT frozen, and `ch_pop_i[0]` clears the flag. For n = 1 to 3, `ch_req_o[n]` is 1 exactly when FIFO n is non-empty and the block is not frozen.
- R10: Each FIFO holds 4 entries. Bit n-1 of `q_empty_o`, `q_full_o` and `q_ovf_o` belongs to channel n. A push into a FIFO that is full before the edge is discarded and sets the sticky overflow bit, even if a pop occurs in the same cycle. A pop of an empty FIFO has no effect.
- R11: After reset, all FIFOs are empty, no overflow bit is set, `ch_req_o` is 0, `ch0_en_o` is 0, `ch0_held_o` is 0 and `frozen_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command sampled at this edge |
| cmd_id_i | input | 2 | Channel ID field |
| cmd_mode_i | input | 2 | Mode field |
| cmd_size_i | input | 3 | Size field |
| ddt_mode_i | input | 1 | Direct-transfer mode bit |
| ch_busy_i | input | 4 | Per-channel transfer in progress |
| ch_pop_i | input | 4 | Engine takes channel request/head |
| ch0_en_set_i | input | 1 | Software write of channel 0 enable |
| q_head_o | output | 15 | Oldest entry of FIFOs 1 to 3, 5 bits each |
| q_empty_o | output | 3 | FIFO empty flags |
| q_full_o | output | 3 | FIFO full flags |
| q_ovf_o | output | 3 | Sticky overflow flags |
| ch_req_o | output | 4 | Request offered to the engine per channel |
| ch0_en_o | output | 1 | Channel 0 enable |
| ch0_held_o | output | 1 | Channel 0 registers held after stop |
| frozen_o | output | 1 | Freeze state |

## Verification
Every result is registered. A command, mode change, pop or enable write presented before edge k shows on the outputs right after edge k, one cycle of latency. The bench changes inputs on the falling edge and advances its reference model once per rising edge. It compares every output 1 ns after that edge, so each expectation is checked in the cycle it becomes due. `ch_req_o` is combinational on registered state only, so it follows the same one-edge timing.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int ID_W   = 2;
  localparam int MODE_W = 2;
  localparam int SIZE_W = 3;
  localparam int CMD_W  = MODE_W + SIZE_W;

  localparam logic [SIZE_W-1:0] STOP_SIZE  = 3'b111;
  localparam logic [MODE_W-1:0] FLUSH_MODE = 2'b10;
  localparam logic [SIZE_W-1:0] FLUSH_SIZE = 3'b110;

  typedef enum logic [1:0] {
    CK_NONE,
    CK_ORD,
    CK_STOP,
    CK_FLUSH
  } cmd_kind_e;
endpackage

// File: rtl/dma_cmd_classify.sv
module dma_cmd_classify
  import dma_cmd_pkg::*;
(
  input  logic              valid_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SIZE_W-1:0] size_i,
  output cmd_kind_e         kind_o
);
  logic on_ch0;
  assign on_ch0 = (id_i == '0);

  always_comb begin
    kind_o = CK_NONE;
    if (valid_i) begin
      if (on_ch0 && mode_i != '0 && size_i == STOP_SIZE)
        kind_o = CK_STOP;
      else if (on_ch0 && mode_i == FLUSH_MODE && size_i == FLUSH_SIZE)
        kind_o = CK_FLUSH;
      else
        kind_o = CK_ORD;
    end
  end
endmodule

// File: rtl/dma_req_fifo.sv
module dma_req_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty_o = (count == '0);
  assign full_o  = (count == FULL_CNT);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovf_o  <= 1'b0;
    end else if (clr_i) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (push_i && full_o) ovf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem[wr_ptr] <= data_i;
  end

  // R10
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> full_o);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R10
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
  // R4
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/dma_freeze_ctl.sv
module dma_freeze_ctl #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ddt_i,
  input  logic [NUM_CH-1:0] busy_i,
  input  logic              flush_i,
  output logic              frozen_o
);
  logic ddt_q, toggle_busy;

  assign toggle_busy = (ddt_i != ddt_q) && (|busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ddt_q    <= 1'b0;
      frozen_o <= 1'b0;
    end else begin
      ddt_q <= ddt_i;
      if (toggle_busy)           frozen_o <= 1'b1;
      else if (flush_i && ddt_i) frozen_o <= 1'b0;
    end
  end

  // R5
  freeze_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ddt_i != ddt_q) && busy_i != '0) |=> frozen_o);
  // R6
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !(flush_i && ddt_i)) |=> frozen_o);
endmodule

// File: rtl/dma_cmd_dec.sv
module dma_cmd_dec
  import dma_cmd_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int Q_DEPTH = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  input  logic [ID_W-1:0]               cmd_id_i,
  input  logic [MODE_W-1:0]             cmd_mode_i,
  input  logic [SIZE_W-1:0]             cmd_size_i,
  input  logic                          ddt_mode_i,
  input  logic [NUM_CH-1:0]             ch_busy_i,
  input  logic [NUM_CH-1:0]             ch_pop_i,
  input  logic                          ch0_en_set_i,
  output logic [(NUM_CH-1)*CMD_W-1:0]   q_head_o,
  output logic [NUM_CH-2:0]             q_empty_o,
  output logic [NUM_CH-2:0]             q_full_o,
  output logic [NUM_CH-2:0]             q_ovf_o,
  output logic [NUM_CH-1:0]             ch_req_o,
  output logic                          ch0_en_o,
  output logic                          ch0_held_o,
  output logic                          frozen_o
);
  localparam int NUM_Q = NUM_CH - 1;

  cmd_kind_e        kind;
  logic             is_ord, is_stop, is_flush, stop_acc, ch0_req_q;
  logic [CMD_W-1:0] payload;

  assign payload = {cmd_mode_i, cmd_size_i};

  dma_cmd_classify u_classify (
    .valid_i (cmd_valid_i),
    .id_i    (cmd_id_i),
    .mode_i  (cmd_mode_i),
    .size_i  (cmd_size_i),
    .kind_o  (kind)
  );

  assign is_ord   = (kind == CK_ORD);
  assign is_stop  = (kind == CK_STOP);
  assign is_flush = (kind == CK_FLUSH);
  assign stop_acc = is_stop && !ch_busy_i[0] && !frozen_o;

  dma_freeze_ctl #(.NUM_CH(NUM_CH)) u_freeze (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ddt_i    (ddt_mode_i),
    .busy_i   (ch_busy_i),
    .flush_i  (is_flush),
    .frozen_o (frozen_o)
  );

  for (genvar n = 1; n <= NUM_Q; n++) begin : g_q
    logic push, pop;
    assign push = is_ord && !frozen_o && (cmd_id_i == ID_W'(n));
    assign pop  = ch_pop_i[n] && !frozen_o;

    dma_req_fifo #(.W(CMD_W), .DEPTH(Q_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (is_flush),
      .push_i  (push),
      .data_i  (payload),
      .pop_i   (pop),
      .head_o  (q_head_o[(n-1)*CMD_W +: CMD_W]),
      .empty_o (q_empty_o[n-1]),
      .full_o  (q_full_o[n-1]),
      .ovf_o   (q_ovf_o[n-1])
    );

    assign ch_req_o[n] = !q_empty_o[n-1] && !frozen_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch0_req_q <= 1'b0;
    end else if (is_flush) begin
      ch0_req_q <= 1'b0;
    end else if (is_ord && !frozen_o && cmd_id_i == '0) begin
      ch0_req_q <= 1'b1;
    end else if (ch_pop_i[0] && !frozen_o) begin
      ch0_req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch0_en_o   <= 1'b0;
      ch0_held_o <= 1'b0;
    end else if (ch0_en_set_i) begin
      ch0_en_o   <= 1'b1;
      ch0_held_o <= 1'b0;
    end else if (stop_acc) begin
      ch0_en_o   <= 1'b0;
      ch0_held_o <= 1'b1;
    end
  end

  assign ch_req_o[0] = ch0_req_q && ch0_en_o && !frozen_o;

  // R7
  frozen_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> (ch_req_o == '0));
  // R2
  stop_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_stop && ch_busy_i[0] && !ch0_en_set_i) |=> ($stable(ch0_en_o) && $stable(ch0_held_o)));
  // R3
  en_held_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ch0_en_o && ch0_held_o));
  // R1
  stop_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_stop && !ch_busy_i[0] && !frozen_o && !ch0_en_set_i) |=> (ch0_held_o && !ch0_en_o));
endmodule

// File: tb/dma_cmd_dec_bench.sv
module dma_cmd_dec_bench;
  localparam int NQ = 3;
  localparam int QD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_id = '0;
  logic [1:0]  cmd_mode = '0;
  logic [2:0]  cmd_size = '0;
  logic        ddt = 1'b0;
  logic [3:0]  busy = '0;
  logic [3:0]  pop = '0;
  logic        en_set = 1'b0;
  logic [14:0] q_head;
  logic [2:0]  q_empty, q_full, q_ovf;
  logic [3:0]  ch_req;
  logic        ch0_en, ch0_held, frozen;

  int n_chk = 0;
  int n_err = 0;

  // reference state
  logic [4:0] mq [NQ][QD];
  int         mcnt [NQ];
  logic       mov [NQ];
  logic       mreq0, men, mheld, mfrz, mddt_q;

  always #2 clk = ~clk;

  dma_cmd_dec u_dma_cmd_dec (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_id_i     (cmd_id),
    .cmd_mode_i   (cmd_mode),
    .cmd_size_i   (cmd_size),
    .ddt_mode_i   (ddt),
    .ch_busy_i    (busy),
    .ch_pop_i     (pop),
    .ch0_en_set_i (en_set),
    .q_head_o     (q_head),
    .q_empty_o    (q_empty),
    .q_full_o     (q_full),
    .q_ovf_o      (q_ovf),
    .ch_req_o     (ch_req),
    .ch0_en_o     (ch0_en),
    .ch0_held_o   (ch0_held),
    .frozen_o     (frozen)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_stop_cmd(logic [1:0] id, logic [1:0] md, logic [2:0] sz);
    return id == 2'd0 && md != 2'd0 && sz == 3'b111;
  endfunction

  function automatic bit is_flush_cmd(logic [1:0] id, logic [1:0] md, logic [2:0] sz);
    return id == 2'd0 && md == 2'b10 && sz == 3'b110;
  endfunction

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin
      mcnt[q] = 0;
      mov[q]  = 1'b0;
      for (int e = 0; e < QD; e++) mq[q][e] = '0;
    end
    mreq0 = 0; men = 0; mheld = 0; mfrz = 0; mddt_q = 0;
  endtask

  task automatic model_step();
    bit fl, st, ord, f0, nf;
    fl  = cmd_valid && is_flush_cmd(cmd_id, cmd_mode, cmd_size);
    st  = cmd_valid && is_stop_cmd(cmd_id, cmd_mode, cmd_size);
    ord = cmd_valid && !fl && !st;
    f0  = mfrz;
    nf  = mfrz;
    if (fl && ddt) nf = 0;
    if (ddt != mddt_q && busy != 0) nf = 1;
    mddt_q = ddt;
    if (en_set) begin men = 1; mheld = 0; end
    else if (st && !busy[0] && !f0) begin men = 0; mheld = 1; end
    if (fl) mreq0 = 0;
    else if (ord && cmd_id == 0 && !f0) mreq0 = 1;
    else if (pop[0] && !f0) mreq0 = 0;
    for (int q = 0; q < NQ; q++) begin
      if (fl) mcnt[q] = 0;
      else begin
        bit psh, was_full;
        psh = ord && !f0 && cmd_id == 2'(q + 1);
        was_full = (mcnt[q] == QD);
        if (psh && was_full) mov[q] = 1;
        if (pop[q+1] && !f0 && mcnt[q] > 0) begin
          for (int e = 0; e < QD - 1; e++) mq[q][e] = mq[q][e+1];
          mcnt[q]--;
        end
        if (psh && !was_full) begin
          mq[q][mcnt[q]] = {cmd_mode, cmd_size};
          mcnt[q]++;
        end
      end
    end
    mfrz = nf;
  endtask

  task automatic compare_all();
    chk("R1 R2 R3 ch0_en", int'(ch0_en), int'(men));
    chk("R1 R3 ch0_held", int'(ch0_held), int'(mheld));
    chk("R5 R6 frozen", int'(frozen), int'(mfrz));
    chk("R7 R9 ch0_req", int'(ch_req[0]), int'(mreq0 && men && !mfrz));
    for (int q = 0; q < NQ; q++) begin
      chk("R7 R9 chn_req", int'(ch_req[q+1]), int'(mcnt[q] > 0 && !mfrz));
      chk("R4 R10 empty", int'(q_empty[q]), int'(mcnt[q] == 0));
      chk("R10 full", int'(q_full[q]), int'(mcnt[q] == QD));
      chk("R7 R10 ovf", int'(q_ovf[q]), int'(mov[q]));
      chk("R8 head", int'(q_head[q*5 +: 5]), mcnt[q] > 0 ? int'(mq[q][0]) : 0);
    end
  endtask

  task automatic idle_inputs();
    cmd_valid = 0; pop = '0; en_set = 0;
  endtask

  // drive at negedge, step model and compare just after posedge
  task automatic cycle();
    @(posedge clk);
    #1;
    model_step();
    compare_all();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic send(input logic [1:0] id, input logic [1:0] md, input logic [2:0] sz);
    cmd_valid = 1; cmd_id = id; cmd_mode = md; cmd_size = sz;
    cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1d));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R11 reset state
    chk("R11 empty", int'(q_empty), 7);
    chk("R11 ovf", int'(q_ovf), 0);
    chk("R11 req", int'(ch_req), 0);
    chk("R11 en/held/frozen", int'({ch0_en, ch0_held, frozen}), 0);
    @(negedge clk);

    // R8 R10: fill ch1 past depth, then drain in order
    for (int i = 0; i < 5; i++) send(2'd1, 2'(i), 3'(i));
    chk("R10 full after 4", int'(q_full[0]), 1);
    chk("R10 ovf on 5th", int'(q_ovf[0]), 1);
    chk("R8 first head", int'(q_head[4:0]), 5'b00000);
    pop = 4'b0010; cycle();
    chk("R8 second head", int'(q_head[4:0]), 5'b01001);
    // R9: ch0 request gated by enable
    send(2'd0, 2'd0, 3'd3);
    chk("R9 req without en", int'(ch_req[0]), 0);
    en_set = 1; cycle();
    chk("R9 req with en", int'(ch_req[0]), 1);
    // R2: stop ignored while ch0 busy
    busy = 4'b0001; send(2'd0, 2'd1, 3'b111);
    chk("R2 en kept", int'(ch0_en), 1);
    busy = 4'b0000;
    // R1: stop accepted when idle
    send(2'd0, 2'd3, 3'b111);
    chk("R1 en cleared", int'(ch0_en), 0);
    chk("R1 held set", int'(ch0_held), 1);
    // R3: enable write restarts
    en_set = 1; cycle();
    chk("R3 held cleared", int'(ch0_held), 0);
    // R5: toggle while busy
    busy = 4'b0100; ddt = 1; cycle();
    busy = 4'b0000;
    chk("R5 frozen", int'(frozen), 1);
    // R7: ordinary command dropped
    send(2'd2, 2'd1, 3'd1);
    chk("R7 ch2 still empty", int'(q_empty[1]), 1);
    // R6: flush with ddt 0 keeps freeze
    ddt = 0; cycle();
    send(2'd0, 2'b10, 3'b110);
    chk("R6 still frozen", int'(frozen), 1);
    ddt = 1; cycle();
    send(2'd0, 2'b10, 3'b110);
    chk("R6 freeze left", int'(frozen), 0);
    chk("R4 queues flushed", int'(q_empty), 7);

    // random phase
    for (int t = 0; t < 4000; t++) begin
      cmd_valid = ($urandom % 2) == 0;
      cmd_id    = 2'($urandom);
      cmd_mode  = 2'($urandom);
      cmd_size  = ($urandom % 3 == 0) ? 3'($urandom % 2 + 6) : 3'($urandom);
      if ($urandom % 6 == 0) begin cmd_id = 0; cmd_mode = 2'b10; cmd_size = 3'b110; end
      pop       = 4'($urandom) & 4'($urandom);
      busy      = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
      en_set    = ($urandom % 16 == 0);
      if ($urandom % 24 == 0) ddt = ~ddt;
      cycle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule